// File: doc/BRIEF.md
# Exception Detector and Vector Selector

This block sits at the completion end of a small in-order processor pipeline. Each clock cycle it looks at the control-register mode bits, the flags that describe the completing instruction, the translation-miss strobes, the top bit of the down-counter, the breakpoint register and the management-interrupt pin. From these it decides whether an exception must be taken. When one is taken it names exactly one exception: it raises `take_exc` for one cycle and gives the handler offset on `vector` and, for program exceptions, a one-hot subtype on `cause` for the status-save register.

Each condition has its own gating. The floating-point program condition uses an OR of two enable-mode bits. The decrementer is triggered by an edge, is held pending and is gated by the external-enable bit. The breakpoint is a word-address compare that has its own enable bit. Privilege checks include moves to and from special registers that have the top register-number bit set. When more than one condition holds in the same cycle, a fixed priority picks the winner. Outputs are registered, so `vector` and `cause` are valid in the same cycle as the `take_exc` pulse.

Top module: `exc_vector_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, take_exc, vector and cause are all 0.
- R2: When ins_valid=1, a program exception (vector 0x00700) is raised in four cases: fe_mode!=0 together with fp_sum_exc=1, ins_illegal=1, a privileged violation (R3), or ins_trap_hit=1. Its cause is one-hot: bit3 means FP-enabled, bit2 illegal, bit1 privileged and bit0 trap. Every other vector has cause 0.
- R3: A privileged violation needs user_mode=1 together with either ins_priv=1, or ins_spr_move=1 with spr_num_msb=1. With user_mode=0 none of these raises anything.
- R4: When ins_valid=1, ins_fp=1 and fp_avail=0, the FP-unavailable vector 0x00800 is raised. With fp_avail=1 this is not raised.
- R5: The decrementer (0x00900) is requested only by a 0-to-1 change of dec_msb. The request stays pending while dec_msb stays 1, and is dropped when dec_msb returns to 0 or when the exception is taken. It is taken only while ext_en=1. After reset, an edge counts only once dec_msb has been seen at 0.
- R6: When ins_valid=1, ins_syscall=1 gives 0x00C00. Trace (0x00D00) is raised when step_en=1, or when ins_branch=1 together with br_trace_en=1.
- R7: itlb_miss gives 0x01000, dload_miss gives 0x01100 and dstore_miss gives 0x01200. These strobes do not depend on ins_valid.
- R8: When ins_valid=1, the breakpoint (0x01300) fires if bp_reg[31:2]==cmpl_addr[31:2] and the enable bit bp_reg[1]=1. Bits [1:0] of the address and bp_reg[0] play no part.
- R9: smi_in=1 with ext_en=1 gives 0x01400. With ext_en=0 it gives nothing.
- R10: Priority, from highest to lowest: instruction-fetch miss, illegal, privileged, FP-unavailable, FP-enabled, trap, system call, load miss, store miss, breakpoint, trace, management interrupt, decrementer.
- R11: Outputs appear in the cycle after the inputs that cause them. take_exc is never high two cycles in a row. Inputs in the cycle where take_exc is high are not acted upon, except that a decrementer edge is still recorded. When take_exc=0, vector and cause are 0.
- R12: The offsets in 0x00A00-0x00BFF, 0x00E00-0x00FFF and 0x01500-0x02FFF are never output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_mode | input | 2 | Floating-point enabled-exception mode bits |
| fp_avail | input | 1 | Floating-point unit available |
| ext_en | input | 1 | External/asynchronous exception enable |
| step_en | input | 1 | Single-step trace enable |
| br_trace_en | input | 1 | Branch trace enable |
| user_mode | input | 1 | Processor in user (unprivileged) mode |
| fp_sum_exc | input | 1 | Floating-point summary exception flag |
| ins_valid | input | 1 | An instruction completes this cycle |
| ins_illegal | input | 1 | Completing instruction has an illegal encoding |
| ins_priv | input | 1 | Completing instruction is privileged |
| ins_spr_move | input | 1 | Completing instruction moves to/from a special register |
| spr_num_msb | input | 1 | Top bit of that special-register number |
| ins_fp | input | 1 | Completing instruction is floating-point (incl. FP load/store) |
| ins_trap_hit | input | 1 | Trap instruction condition met |
| ins_syscall | input | 1 | Completing instruction is a system call |
| ins_branch | input | 1 | Completing instruction is a branch |
| dec_msb | input | 1 | Most significant bit of the down-counter |
| bp_reg | input | 32 | Breakpoint register: [31:2] word address, [1] enable |
| cmpl_addr | input | 32 | Address of the completing instruction |
| smi_in | input | 1 | Management interrupt pin |
| itlb_miss | input | 1 | Instruction-fetch translation miss strobe |
| dload_miss | input | 1 | Data-load translation miss strobe |
| dstore_miss | input | 1 | Data-store translation miss strobe |
| take_exc | output | 1 | One-cycle pulse: exception taken |
| vector | output | 20 | Handler offset of the taken exception |
| cause | output | 4 | One-hot program-exception subtype |

## Verification
First, each condition is driven on its own and next to the near-miss that must not fire. Examples are supervisor-mode privileged opcodes, an FP flag with both mode bits clear, a breakpoint with the enable bit cleared or a different word address, and a branch without branch-trace. This separates the gating terms from the plain decode. Directed pairs of simultaneous conditions fix the priority order across the synchronous, trace/breakpoint and asynchronous groups. A decrementer sequence checks the edge, the pending hold while ext_en=0, the loss on MSB fall and the recovery after a blocked cycle. Weighted random cycles, with several strobes often active together, are compared against a bench model. They exercise mixed priorities and back-to-back requests that hit the post-take blocking cycle.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

    localparam int VEC_W   = 20;
    localparam int CAUSE_W = 4;
    localparam int NUM_EXC = 13;

    // Index order is the priority order: lower index wins.
    typedef enum logic [3:0] {
        EX_ITLB    = 4'd0,
        EX_ILLEGAL = 4'd1,
        EX_PRIV    = 4'd2,
        EX_FPUNAV  = 4'd3,
        EX_FPENAB  = 4'd4,
        EX_TRAP    = 4'd5,
        EX_SYSCALL = 4'd6,
        EX_DLOAD   = 4'd7,
        EX_DSTORE  = 4'd8,
        EX_BKPT    = 4'd9,
        EX_TRACE   = 4'd10,
        EX_SMI     = 4'd11,
        EX_DEC     = 4'd12
    } exc_id_e;

    typedef struct packed {
        logic               take;
        logic [VEC_W-1:0]   vec;
        logic [CAUSE_W-1:0] cause;
    } exc_out_t;

    typedef struct packed {
        logic prev_msb;
        logic pend;
    } dec_st_t;

    function automatic logic [VEC_W-1:0] vec_of(exc_id_e id);
        logic [VEC_W-1:0] v;
        case (id)
            EX_ILLEGAL, EX_PRIV,
            EX_FPENAB, EX_TRAP: v = 20'h00700;
            EX_FPUNAV:          v = 20'h00800;
            EX_DEC:             v = 20'h00900;
            EX_SYSCALL:         v = 20'h00C00;
            EX_TRACE:           v = 20'h00D00;
            EX_ITLB:            v = 20'h01000;
            EX_DLOAD:           v = 20'h01100;
            EX_DSTORE:          v = 20'h01200;
            EX_BKPT:            v = 20'h01300;
            EX_SMI:             v = 20'h01400;
            default:            v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [CAUSE_W-1:0] cause_of(exc_id_e id);
        logic [CAUSE_W-1:0] c;
        case (id)
            EX_FPENAB:  c = 4'b1000;
            EX_ILLEGAL: c = 4'b0100;
            EX_PRIV:    c = 4'b0010;
            EX_TRAP:    c = 4'b0001;
            default:    c = 4'b0000;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/exc_dec_edge.sv
module exc_dec_edge
    import exc_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dec_msb,
    input  logic ext_en,
    input  logic taken,
    output logic dec_req
);

    dec_st_t st_d, st_q;
    logic    rise;

    assign rise    = dec_msb & ~st_q.prev_msb;
    assign dec_req = ext_en & ((st_q.pend & dec_msb) | rise);

    always_comb begin
        st_d          = st_q;
        st_d.prev_msb = dec_msb;
        st_d.pend     = (st_q.pend | rise) & dec_msb & ~taken;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev_msb <= 1'b1;
            st_q.pend     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    p_dec_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_req |-> (dec_msb && ext_en));

    p_pend_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_msb |=> !st_q.pend);

endmodule

// File: rtl/exc_cond_detect.sv
module exc_cond_detect
    import exc_sel_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        fe_mode,
    input  logic              fp_avail,
    input  logic              ext_en,
    input  logic              step_en,
    input  logic              br_trace_en,
    input  logic              user_mode,
    input  logic              fp_sum_exc,
    input  logic              ins_valid,
    input  logic              ins_illegal,
    input  logic              ins_priv,
    input  logic              ins_spr_move,
    input  logic              spr_num_msb,
    input  logic              ins_fp,
    input  logic              ins_trap_hit,
    input  logic              ins_syscall,
    input  logic              ins_branch,
    input  logic [ADDR_W-1:0] bp_reg,
    input  logic [ADDR_W-1:0] cmpl_addr,
    input  logic              smi_in,
    input  logic              itlb_miss,
    input  logic              dload_miss,
    input  logic              dstore_miss,
    input  logic              dec_req,
    output logic [NUM_EXC-1:0] req
);

    localparam int CMP_LSB = 2;
    localparam int EN_BIT  = 1;
    localparam int CMP_N   = ADDR_W - CMP_LSB;

    logic [CMP_N-1:0] bit_eq;
    logic             addr_hit;
    logic             unused_bits;

    genvar g;
    generate
        for (g = 0; g < CMP_N; g++) begin : g_cmp
            assign bit_eq[g] = ~(bp_reg[g+CMP_LSB] ^ cmpl_addr[g+CMP_LSB]);
        end
    endgenerate

    assign addr_hit    = &bit_eq;
    assign unused_bits = ^{bp_reg[0], cmpl_addr[CMP_LSB-1:0]};

    always_comb begin
        req              = '0;
        req[EX_ITLB]     = itlb_miss;
        req[EX_ILLEGAL]  = ins_valid & ins_illegal;
        req[EX_PRIV]     = ins_valid & user_mode &
                           (ins_priv | (ins_spr_move & spr_num_msb));
        req[EX_FPUNAV]   = ins_valid & ins_fp & ~fp_avail;
        req[EX_FPENAB]   = ins_valid & (|fe_mode) & fp_sum_exc;
        req[EX_TRAP]     = ins_valid & ins_trap_hit;
        req[EX_SYSCALL]  = ins_valid & ins_syscall;
        req[EX_DLOAD]    = dload_miss;
        req[EX_DSTORE]   = dstore_miss;
        req[EX_BKPT]     = ins_valid & bp_reg[EN_BIT] & addr_hit;
        req[EX_TRACE]    = ins_valid & (step_en | (ins_branch & br_trace_en));
        req[EX_SMI]      = smi_in & ext_en;
        req[EX_DEC]      = dec_req;
    end

endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_sel_pkg::*;
(
    input  logic [NUM_EXC-1:0] req,
    output logic               any,
    output exc_id_e            grant
);

    always_comb begin
        any   = 1'b0;
        grant = EX_ITLB;
        for (int i = NUM_EXC - 1; i >= 0; i--) begin
            if (req[i]) begin
                any   = 1'b1;
                grant = exc_id_e'(4'(i));
            end
        end
    end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_sel_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fe_mode,
    input  logic              fp_avail,
    input  logic              ext_en,
    input  logic              step_en,
    input  logic              br_trace_en,
    input  logic              user_mode,
    input  logic              fp_sum_exc,
    input  logic              ins_valid,
    input  logic              ins_illegal,
    input  logic              ins_priv,
    input  logic              ins_spr_move,
    input  logic              spr_num_msb,
    input  logic              ins_fp,
    input  logic              ins_trap_hit,
    input  logic              ins_syscall,
    input  logic              ins_branch,
    input  logic              dec_msb,
    input  logic [ADDR_W-1:0] bp_reg,
    input  logic [ADDR_W-1:0] cmpl_addr,
    input  logic              smi_in,
    input  logic              itlb_miss,
    input  logic              dload_miss,
    input  logic              dstore_miss,
    output logic              take_exc,
    output logic [VEC_W-1:0]  vector,
    output logic [CAUSE_W-1:0] cause
);

    exc_out_t           out_d, out_q;
    logic [NUM_EXC-1:0] raw_req;
    logic [NUM_EXC-1:0] live_req;
    logic               dec_req;
    logic               any_win;
    exc_id_e            win_id;
    logic               dec_taken;

    exc_dec_edge u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_msb (dec_msb),
        .ext_en  (ext_en),
        .taken   (dec_taken),
        .dec_req (dec_req)
    );

    exc_cond_detect #(.ADDR_W(ADDR_W)) u_cond (
        .fe_mode      (fe_mode),
        .fp_avail     (fp_avail),
        .ext_en       (ext_en),
        .step_en      (step_en),
        .br_trace_en  (br_trace_en),
        .user_mode    (user_mode),
        .fp_sum_exc   (fp_sum_exc),
        .ins_valid    (ins_valid),
        .ins_illegal  (ins_illegal),
        .ins_priv     (ins_priv),
        .ins_spr_move (ins_spr_move),
        .spr_num_msb  (spr_num_msb),
        .ins_fp       (ins_fp),
        .ins_trap_hit (ins_trap_hit),
        .ins_syscall  (ins_syscall),
        .ins_branch   (ins_branch),
        .bp_reg       (bp_reg),
        .cmpl_addr    (cmpl_addr),
        .smi_in       (smi_in),
        .itlb_miss    (itlb_miss),
        .dload_miss   (dload_miss),
        .dstore_miss  (dstore_miss),
        .dec_req      (dec_req),
        .req          (raw_req)
    );

    // The cycle after a take is the flush cycle: nothing is accepted.
    assign live_req = out_q.take ? '0 : raw_req;

    exc_prio_sel u_prio (
        .req   (live_req),
        .any   (any_win),
        .grant (win_id)
    );

    assign dec_taken = any_win & (win_id == EX_DEC);

    always_comb begin
        out_d       = '0;
        out_d.take  = any_win;
        if (any_win) begin
            out_d.vec   = vec_of(win_id);
            out_d.cause = cause_of(win_id);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign take_exc = out_q.take;
    assign vector   = out_q.vec;
    assign cause    = out_q.cause;

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |=> !take_exc);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !take_exc |-> (vector == '0 && cause == '0));

    p_prog_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && vector == 20'h00700) |-> ($countones(cause) == 1));

    p_other_nocause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && vector != 20'h00700) |-> (cause == '0));

    p_no_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> !((vector >= 20'h00A00 && vector <= 20'h00BFF) ||
                       (vector >= 20'h00E00 && vector <= 20'h00FFF) ||
                       (vector >= 20'h01500 && vector <= 20'h02FFF)));

    p_bp_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        raw_req[EX_BKPT] |-> bp_reg[1]);

    p_smi_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && vector == 20'h01400) |-> $past(ext_en));

endmodule

// File: tb/tb_exc_vector_sel.sv
`timescale 1ns/1ps
module tb_exc_vector_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fe_mode;
    logic        fp_avail, ext_en, step_en, br_trace_en, user_mode, fp_sum_exc;
    logic        ins_valid, ins_illegal, ins_priv, ins_spr_move, spr_num_msb;
    logic        ins_fp, ins_trap_hit, ins_syscall, ins_branch, dec_msb;
    logic [31:0] bp_reg, cmpl_addr;
    logic        smi_in, itlb_miss, dload_miss, dstore_miss;
    logic        take_exc;
    logic [19:0] vector;
    logic [3:0]  cause;

    int n_chk = 0;
    int n_bad = 0;

    logic        m_prev = 1'b1;
    logic        m_pend = 1'b0;
    logic        m_blk  = 1'b0;
    logic        exp_take;
    logic [19:0] exp_vec;
    logic [3:0]  exp_cause;

    always #2 clk = ~clk;

    exc_vector_sel dut (
        .clk(clk), .rst_n(rst_n), .fe_mode(fe_mode), .fp_avail(fp_avail),
        .ext_en(ext_en), .step_en(step_en), .br_trace_en(br_trace_en),
        .user_mode(user_mode), .fp_sum_exc(fp_sum_exc), .ins_valid(ins_valid),
        .ins_illegal(ins_illegal), .ins_priv(ins_priv), .ins_spr_move(ins_spr_move),
        .spr_num_msb(spr_num_msb), .ins_fp(ins_fp), .ins_trap_hit(ins_trap_hit),
        .ins_syscall(ins_syscall), .ins_branch(ins_branch), .dec_msb(dec_msb),
        .bp_reg(bp_reg), .cmpl_addr(cmpl_addr), .smi_in(smi_in),
        .itlb_miss(itlb_miss), .dload_miss(dload_miss), .dstore_miss(dstore_miss),
        .take_exc(take_exc), .vector(vector), .cause(cause)
    );

    function automatic logic [19:0] exp_vec_of(int w);
        case (w)
            0: return 20'h01000;
            1, 2, 4, 5: return 20'h00700;
            3: return 20'h00800;
            6: return 20'h00C00;
            7: return 20'h01100;
            8: return 20'h01200;
            9: return 20'h01300;
            10: return 20'h00D00;
            11: return 20'h01400;
            12: return 20'h00900;
            default: return 20'h0;
        endcase
    endfunction

    function automatic logic [3:0] exp_cause_of(int w);
        case (w)
            1: return 4'b0100;
            2: return 4'b0010;
            4: return 4'b1000;
            5: return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic model_step();
        logic        rise, dreq;
        logic [12:0] r;
        int          w;
        rise = dec_msb && !m_prev;
        dreq = ext_en && ((m_pend && dec_msb) || rise);
        r[0]  = itlb_miss;
        r[1]  = ins_valid && ins_illegal;
        r[2]  = ins_valid && user_mode && (ins_priv || (ins_spr_move && spr_num_msb));
        r[3]  = ins_valid && ins_fp && !fp_avail;
        r[4]  = ins_valid && (fe_mode != 2'b00) && fp_sum_exc;
        r[5]  = ins_valid && ins_trap_hit;
        r[6]  = ins_valid && ins_syscall;
        r[7]  = dload_miss;
        r[8]  = dstore_miss;
        r[9]  = ins_valid && bp_reg[1] && (bp_reg[31:2] == cmpl_addr[31:2]);
        r[10] = ins_valid && (step_en || (ins_branch && br_trace_en));
        r[11] = smi_in && ext_en;
        r[12] = dreq;
        if (m_blk) r = '0;
        w = -1;
        for (int i = 0; i < 13; i++) if (w < 0 && r[i]) w = i;
        exp_take  = (w >= 0);
        exp_vec   = exp_vec_of(w);
        exp_cause = exp_cause_of(w);
        m_pend = (m_pend || rise) && dec_msb && (w != 12);
        m_prev = dec_msb;
        m_blk  = exp_take;
    endtask

    task automatic check_out(string tag);
        n_chk++;
        if (take_exc !== exp_take || vector !== exp_vec || cause !== exp_cause) begin
            n_bad++;
            $display("FAIL %s: take=%b vec=%05h cause=%b expected take=%b vec=%05h cause=%b",
                     tag, take_exc, vector, cause, exp_take, exp_vec, exp_cause);
        end
        if (take_exc === 1'b1 &&
            ((vector >= 20'h00A00 && vector <= 20'h00BFF) ||
             (vector >= 20'h00E00 && vector <= 20'h00FFF) ||
             (vector >= 20'h01500 && vector <= 20'h02FFF))) begin
            n_bad++;
            $display("FAIL R12: reserved vector %05h, expected none", vector);
        end
    endtask

    task automatic run_cyc(string tag);
        model_step();
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic clear_in();
        fe_mode = 2'b00; fp_avail = 1'b1; ext_en = 1'b0; step_en = 1'b0;
        br_trace_en = 1'b0; user_mode = 1'b0; fp_sum_exc = 1'b0; ins_valid = 1'b0;
        ins_illegal = 1'b0; ins_priv = 1'b0; ins_spr_move = 1'b0; spr_num_msb = 1'b0;
        ins_fp = 1'b0; ins_trap_hit = 1'b0; ins_syscall = 1'b0; ins_branch = 1'b0;
        bp_reg = 32'h0; cmpl_addr = 32'h0000_1000;
        smi_in = 1'b0; itlb_miss = 1'b0; dload_miss = 1'b0; dstore_miss = 1'b0;
    endtask

    // one stimulus cycle, then an idle cycle so the flush cycle is clean
    task automatic pulse(string tag);
        run_cyc(tag);
        clear_in();
        run_cyc(tag);
    endtask

    function automatic logic rb(int n);
        return ($urandom % n) == 0;
    endfunction

    initial begin
        #(4ns * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_in();
        dec_msb = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (take_exc !== 1'b0 || vector !== 20'h0 || cause !== 4'h0) begin
            n_bad++;
            $display("FAIL R1: take=%b vec=%05h cause=%b expected 0/0/0", take_exc, vector, cause);
        end
        rst_n = 1'b1;
        exp_take = 1'b0; exp_vec = '0; exp_cause = '0;
        run_cyc("R1 after reset");

        // R7 translation misses, with and without ins_valid
        itlb_miss = 1'b1;  pulse("R7 fetch miss");
        dload_miss = 1'b1; pulse("R7 load miss");
        dstore_miss = 1'b1; ins_valid = 1'b1; pulse("R7 store miss");

        // R2 program subtypes
        ins_valid = 1'b1; ins_illegal = 1'b1; pulse("R2 illegal");
        ins_illegal = 1'b1; pulse("R2 illegal without valid");
        ins_valid = 1'b1; fe_mode = 2'b01; fp_sum_exc = 1'b1; pulse("R2 fp enabled mode01");
        ins_valid = 1'b1; fe_mode = 2'b10; fp_sum_exc = 1'b1; pulse("R2 fp enabled mode10");
        ins_valid = 1'b1; fe_mode = 2'b00; fp_sum_exc = 1'b1; pulse("R2 fp modes off");
        ins_valid = 1'b1; ins_trap_hit = 1'b1; pulse("R2 trap");

        // R3 privilege
        ins_valid = 1'b1; user_mode = 1'b1; ins_priv = 1'b1; pulse("R3 user priv");
        ins_valid = 1'b1; user_mode = 1'b0; ins_priv = 1'b1; pulse("R3 supervisor priv");
        ins_valid = 1'b1; user_mode = 1'b1; ins_spr_move = 1'b1; spr_num_msb = 1'b1;
        pulse("R3 spr msb1 user");
        ins_valid = 1'b1; user_mode = 1'b1; ins_spr_move = 1'b1; spr_num_msb = 1'b0;
        pulse("R3 spr msb0 user");

        // R4 FP unavailable
        ins_valid = 1'b1; ins_fp = 1'b1; fp_avail = 1'b0; pulse("R4 fp off");
        ins_valid = 1'b1; ins_fp = 1'b1; fp_avail = 1'b1; pulse("R4 fp on");

        // R6 syscall and trace
        ins_valid = 1'b1; ins_syscall = 1'b1; pulse("R6 syscall");
        ins_valid = 1'b1; step_en = 1'b1; pulse("R6 single step");
        ins_valid = 1'b1; ins_branch = 1'b1; br_trace_en = 1'b1; pulse("R6 branch trace");
        ins_valid = 1'b1; ins_branch = 1'b1; br_trace_en = 1'b0; pulse("R6 branch no trace");

        // R8 breakpoint
        ins_valid = 1'b1; bp_reg = 32'h0000_2002; cmpl_addr = 32'h0000_2000; pulse("R8 match");
        ins_valid = 1'b1; bp_reg = 32'h0000_2003; cmpl_addr = 32'h0000_2003; pulse("R8 low bits ignored");
        ins_valid = 1'b1; bp_reg = 32'h0000_2000; cmpl_addr = 32'h0000_2000; pulse("R8 disabled");
        ins_valid = 1'b1; bp_reg = 32'h8000_2002; cmpl_addr = 32'h0000_2000; pulse("R8 addr differs");

        // R9 management interrupt
        smi_in = 1'b1; ext_en = 1'b1; pulse("R9 smi enabled");
        smi_in = 1'b1; ext_en = 1'b0; pulse("R9 smi masked");

        // R5 decrementer
        dec_msb = 1'b1; ext_en = 1'b0;
        run_cyc("R5 edge masked"); run_cyc("R5 held masked");
        ext_en = 1'b1; run_cyc("R5 pending taken");
        run_cyc("R5 no retake"); run_cyc("R5 no retake 2");
        dec_msb = 1'b0; run_cyc("R5 msb low");
        dec_msb = 1'b1; ext_en = 1'b0; run_cyc("R5 second edge masked");
        dec_msb = 1'b0; run_cyc("R5 pending lost");
        ext_en = 1'b1; run_cyc("R5 nothing pending");

        // R10 priority pairs
        itlb_miss = 1'b1; ins_valid = 1'b1; ins_illegal = 1'b1; pulse("R10 itlb over illegal");
        ins_valid = 1'b1; ins_illegal = 1'b1; user_mode = 1'b1; ins_priv = 1'b1; pulse("R10 illegal over priv");
        ins_valid = 1'b1; user_mode = 1'b1; ins_priv = 1'b1; ins_fp = 1'b1; fp_avail = 1'b0;
        pulse("R10 priv over fpunav");
        ins_valid = 1'b1; ins_fp = 1'b1; fp_avail = 1'b0; fe_mode = 2'b11; fp_sum_exc = 1'b1;
        pulse("R10 fpunav over fpenab");
        ins_valid = 1'b1; ins_trap_hit = 1'b1; ins_syscall = 1'b1; pulse("R10 trap over syscall");
        ins_valid = 1'b1; ins_syscall = 1'b1; dload_miss = 1'b1; pulse("R10 syscall over load");
        dload_miss = 1'b1; dstore_miss = 1'b1; pulse("R10 load over store");
        ins_valid = 1'b1; bp_reg = 32'h0000_1002; step_en = 1'b1; pulse("R10 bkpt over trace");
        ins_valid = 1'b1; step_en = 1'b1; smi_in = 1'b1; ext_en = 1'b1; pulse("R10 trace over smi");
        dec_msb = 1'b1; smi_in = 1'b1; ext_en = 1'b1;
        run_cyc("R10 smi over dec"); smi_in = 1'b0;
        run_cyc("R11 flush cycle"); run_cyc("R5 dec after flush");
        dec_msb = 1'b0; run_cyc("R5 idle");

        // R11 back-to-back requests
        ins_valid = 1'b1; ins_syscall = 1'b1;
        run_cyc("R11 first take"); run_cyc("R11 blocked"); run_cyc("R11 take again");
        clear_in(); run_cyc("R11 idle");

        // R10 random mixes
        for (int k = 0; k < 4000; k++) begin
            fe_mode      = 2'($urandom);
            fp_avail     = !rb(3);
            ext_en       = !rb(3);
            step_en      = rb(10);
            br_trace_en  = rb(2);
            user_mode    = rb(2);
            fp_sum_exc   = rb(6);
            ins_valid    = !rb(4);
            ins_illegal  = rb(12);
            ins_priv     = rb(8);
            ins_spr_move = rb(6);
            spr_num_msb  = rb(2);
            ins_fp       = rb(6);
            ins_trap_hit = rb(12);
            ins_syscall  = rb(12);
            ins_branch   = rb(4);
            if (rb(6)) dec_msb = !dec_msb;
            cmpl_addr    = {20'h0, 10'($urandom), 2'($urandom)};
            bp_reg       = rb(5) ? {cmpl_addr[31:2], 1'b1, 1'($urandom)}
                                 : {20'h0, 10'($urandom), 2'($urandom)};
            smi_in       = rb(10);
            itlb_miss    = rb(14);
            dload_miss   = rb(12);
            dstore_miss  = rb(12);
            run_cyc("R10 random");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule